// File: doc/BRIEF.md
# Translation Table Base Register Bank

This block holds the base-address words that an interrupt translation unit uses to find its in-memory tables. It has eight 64-bit slots on the register bus. Slot 0 describes the device table and slot 1 describes the collection table. The other six slots are reserved. They read as zero and drop writes. The two live values go straight out to the table-walk logic as `dev_base` and `coll_base`.

The register bus can make 32-bit or 64-bit accesses.
- A 32-bit access uses one half of a slot, selected by address bit 2.
- Only the bytes of that half are merged into the stored word.

Every write is rewritten into a fixed, supported configuration before it is stored:
- the table type code and the entry-size code are forced in;
- page size is pinned to 64 KiB;
- high physical-address bits that are not supported are cleared;
- a reserved shareability code is replaced;
- on the collection slot, the two-level (indirect) flag is cleared.

While the unit is enabled, the bank rejects all writes.

Top module: `itu_tbase_bank`

## Requirements
- R1: The slot index is address bits [5:3]; higher address bits are ignored. Slot 0 drives `dev_base` and slot 1 drives `coll_base`.
- R2: Slots 2 to 7 read as zero, and a write to any of them changes neither `dev_base` nor `coll_base`.
- R3: While `unit_en` is 1, a write to any slot leaves both stored words unchanged.
- R4: A 64-bit access writes all eight bytes. A 32-bit access writes `wr_data[31:0]` into bits [63:32] when address bit 2 is 1, or into bits [31:0] when it is 0, and keeps the other half. A 32-bit read returns the addressed half in `rd_data[31:0]`, with `rd_data[63:32]` at zero.
- R5: After any write, bits [58:56] hold the type code (1 for the device slot, 4 for the collection slot). Bits [52:48] hold the slot's entry size in bytes minus 1, whatever was written to those bits.
- R6: After any write, bits [9:8] hold 2 (64 KiB pages) and bits [15:12] are zero.
- R7: A write to the collection slot always clears bit 62. On the device slot, bit 62 is stored as written.
- R8: A written shareability value of 3 in bits [11:10] is stored as 1, and other shareability values are kept. Cacheability fields (bits [61:59] inner, [55:53] outer) are stored as written, including 0.
- R9: After reset, each slot holds:
  - entry-size code = entry size − 1 (7 for the default 8 bytes);
  - page-size code 2;
  - inner cacheability 3, outer cacheability 0;
  - shareability 1;
  - its type code.

  With default parameters this gives `dev_base` = 0x1907000000000600 and `coll_base` = 0x1C07000000000600.
- R10: A write is seen on `dev_base`/`coll_base` after the first rising clock edge that samples `wr_en`, and not before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_en | input | 1 | Translation unit enabled; writes to the bank are refused |
| acc_addr | input | ADDR_W | Byte address of the access within the bank |
| acc_64 | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| wr_en | input | 1 | Write strobe for the current access |
| wr_data | input | 64 | Write data (32-bit accesses use bits [31:0]) |
| rd_data | output | 64 | Read data for the addressed slot and half |
| dev_base | output | 64 | Sanitised device-table base word |
| coll_base | output | 64 | Sanitised collection-table base word |

## Verification
A vector table drives these write patterns into the two live slots:
- All-ones words, which show every forced field and cleared bit against a fully set input.
- All-zero words, which show that cacheability zero survives while the type and size codes still appear.
- A lower-half word with shareability 3 and address bits [15:12] set, which separates the shareability rewrite from the address-bit clearing.
- An upper-half word with only bit 62 set, which shows the device slot keeping that bit while the collection slot drops it.

Writes to reserved slots, and an aliased address above bit 5, check the index decode. A write made while enabled checks the lock. Half-word reads, and a look before the clock edge, check lane selection and timing.

// File: rtl/itu_tbase_pkg.sv
package itu_tbase_pkg;

  typedef logic [63:0] tbase_t;

  // field positions inside a table base word
  localparam int TYPE_LO = 56;
  localparam int ESZ_LO  = 48;
  localparam int PG_LO   = 8;
  localparam int SHR_LO  = 10;
  localparam int PAHI_LO = 12;
  localparam int IND_BIT = 62;
  localparam int ICA_LO  = 59;
  localparam int OCA_LO  = 53;

  localparam logic [2:0] TYPE_DEV  = 3'd1;
  localparam logic [2:0] TYPE_COLL = 3'd4;
  localparam logic [1:0] PG_64K    = 2'd2;
  localparam logic [1:0] SHR_INNER = 2'd1;
  localparam logic [1:0] SHR_RSVD  = 2'd3;
  localparam logic [2:0] ICA_RAWB  = 3'd3;
  localparam logic [2:0] OCA_SAME  = 3'd0;

  function automatic tbase_t reset_word(input logic [2:0] ty, input logic [4:0] esz_code);
    tbase_t w;
    w = '0;
    w[TYPE_LO +: 3] = ty;
    w[ESZ_LO  +: 5] = esz_code;
    w[PG_LO   +: 2] = PG_64K;
    w[SHR_LO  +: 2] = SHR_INNER;
    w[ICA_LO  +: 3] = ICA_RAWB;
    w[OCA_LO  +: 3] = OCA_SAME;
    return w;
  endfunction

endpackage

// File: rtl/itu_tbase_merge.sv
module itu_tbase_merge
  import itu_tbase_pkg::*;
(
  input  tbase_t      old_word,
  input  logic [63:0] wr_data,
  input  logic        acc_64,
  input  logic        upper,
  output tbase_t      merged
);

  always_comb begin
    merged = old_word;
    if (acc_64) begin
      merged = wr_data;
    end else if (upper) begin
      merged[63:32] = wr_data[31:0];
    end else begin
      merged[31:0] = wr_data[31:0];
    end
  end

endmodule

// File: rtl/itu_tbase_sanitise.sv
module itu_tbase_sanitise
  import itu_tbase_pkg::*;
#(
  parameter logic [2:0] TYPE_CODE = TYPE_DEV,
  parameter int         ESIZE     = 8,
  parameter bit         CLR_IND   = 1'b0
) (
  input  tbase_t raw,
  output tbase_t clean
);

  localparam logic [4:0] ESZ_CODE = 5'(ESIZE - 1);

  always_comb begin
    clean = raw;
    clean[TYPE_LO +: 3] = TYPE_CODE;
    clean[ESZ_LO  +: 5] = ESZ_CODE;
    clean[PG_LO   +: 2] = PG_64K;
    clean[PAHI_LO +: 4] = 4'h0;
    if (raw[SHR_LO +: 2] == SHR_RSVD) begin
      clean[SHR_LO +: 2] = SHR_INNER;
    end
    if (CLR_IND) begin
      clean[IND_BIT] = 1'b0;
    end
  end

endmodule

// File: rtl/itu_tbase_slot.sv
module itu_tbase_slot
  import itu_tbase_pkg::*;
#(
  parameter logic [2:0] TYPE_CODE = TYPE_DEV,
  parameter int         ESIZE     = 8,
  parameter bit         CLR_IND   = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        unit_en,
  input  logic        wr_hit,
  input  logic        acc_64,
  input  logic        upper,
  input  logic [63:0] wr_data,
  output tbase_t      q
);

  localparam tbase_t RST_WORD = reset_word(TYPE_CODE, 5'(ESIZE - 1));

  tbase_t merged, clean, q_nxt;
  logic   load;

  itu_tbase_merge u_merge (
    .old_word (q),
    .wr_data  (wr_data),
    .acc_64   (acc_64),
    .upper    (upper),
    .merged   (merged)
  );

  itu_tbase_sanitise #(
    .TYPE_CODE (TYPE_CODE),
    .ESIZE     (ESIZE),
    .CLR_IND   (CLR_IND)
  ) u_sanit (
    .raw   (merged),
    .clean (clean)
  );

  always_comb begin
    load  = wr_hit && !unit_en;
    q_nxt = load ? clean : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= RST_WORD;
    end else if (load) begin
      q <= q_nxt;
    end
  end

  // R3
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unit_en |=> $stable(q));

  // R5
  type_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[TYPE_LO +: 3] == TYPE_CODE) && (q[ESZ_LO +: 5] == 5'(ESIZE - 1)));

  // R6
  page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q[PG_LO +: 2] == PG_64K) && (q[PAHI_LO +: 4] == 4'h0));

  // R8
  shr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q[SHR_LO +: 2] != SHR_RSVD);

  generate
    if (CLR_IND) begin : g_ind
      // R7
      ind_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !q[IND_BIT]);
    end
  endgenerate

endmodule

// File: rtl/itu_tbase_bank.sv
module itu_tbase_bank
  import itu_tbase_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int NUM_SLOTS  = 8,
  parameter int DEV_ESIZE  = 8,
  parameter int COLL_ESIZE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              unit_en,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic              acc_64,
  input  logic              wr_en,
  input  logic [63:0]       wr_data,
  output logic [63:0]       rd_data,
  output logic [63:0]       dev_base,
  output logic [63:0]       coll_base
);

  localparam int SLOT_W   = $clog2(NUM_SLOTS);
  localparam int NUM_IMPL = 2;

  logic [SLOT_W-1:0] slot_idx;
  logic              upper;
  tbase_t            slot_q [NUM_IMPL];
  tbase_t            sel_word;

  assign slot_idx = acc_addr[3 +: SLOT_W];
  assign upper    = acc_addr[2];

  generate
    for (genvar i = 0; i < NUM_IMPL; i++) begin : g_slot
      localparam logic [2:0] TY = (i == 0) ? TYPE_DEV : TYPE_COLL;
      localparam int         ES = (i == 0) ? DEV_ESIZE : COLL_ESIZE;
      localparam bit         CI = (i != 0);
      itu_tbase_slot #(
        .TYPE_CODE (TY),
        .ESIZE     (ES),
        .CLR_IND   (CI)
      ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .unit_en (unit_en),
        .wr_hit  (wr_en && (slot_idx == SLOT_W'(i))),
        .acc_64  (acc_64),
        .upper   (upper),
        .wr_data (wr_data),
        .q       (slot_q[i])
      );
    end
  endgenerate

  always_comb begin
    sel_word = '0;
    for (int i = 0; i < NUM_IMPL; i++) begin
      if (slot_idx == SLOT_W'(i)) sel_word = slot_q[i];
    end
    if (acc_64)     rd_data = sel_word;
    else if (upper) rd_data = {32'h0, sel_word[63:32]};
    else            rd_data = {32'h0, sel_word[31:0]};
  end

  assign dev_base  = slot_q[0];
  assign coll_base = slot_q[1];

  // R2
  void_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (slot_idx >= SLOT_W'(NUM_IMPL))) |=> ($stable(dev_base) && $stable(coll_base)));

  // R4
  rd_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_64 |-> (rd_data[63:32] == 32'h0));

endmodule

// File: tb/tb_itu_tbase_bank.sv
module tb_itu_tbase_bank;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        unit_en;
  logic [7:0]  acc_addr;
  logic        acc_64;
  logic        wr_en;
  logic [63:0] wr_data;
  logic [63:0] rd_data, dev_base, coll_base;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  itu_tbase_bank dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .unit_en   (unit_en),
    .acc_addr  (acc_addr),
    .acc_64    (acc_64),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_data   (rd_data),
    .dev_base  (dev_base),
    .coll_base (coll_base)
  );

  // {addr, acc_64, wr_data, expected dev_base, expected coll_base}
  localparam int NV = 9;
  localparam logic [200:0] VEC [NV] = '{
    {8'h00, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF9E7_FFFF_FFFF_06FF, 64'h1C07_0000_0000_0600},
    {8'h08, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hF9E7_FFFF_FFFF_06FF, 64'hBCE7_FFFF_FFFF_06FF},
    {8'h0C, 1'b0, 64'h0000_0000_0000_0000, 64'hF9E7_FFFF_FFFF_06FF, 64'h0407_0000_FFFF_06FF},
    {8'h00, 1'b0, 64'h0000_0000_1234_5C00, 64'hF9E7_FFFF_1234_0600, 64'h0407_0000_FFFF_06FF},
    {8'h00, 1'b0, 64'h0000_0000_0000_0A55, 64'hF9E7_FFFF_0000_0A55, 64'h0407_0000_FFFF_06FF},
    {8'h04, 1'b0, 64'h0000_0000_4000_0000, 64'h4107_0000_0000_0A55, 64'h0407_0000_FFFF_06FF},
    {8'h10, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4107_0000_0000_0A55, 64'h0407_0000_FFFF_06FF},
    {8'h38, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h4107_0000_0000_0A55, 64'h0407_0000_FFFF_06FF},
    {8'h48, 1'b1, 64'h0000_0000_0000_0000, 64'h4107_0000_0000_0A55, 64'h0407_0000_0000_0200}
  };

  localparam string VTAG [NV] = '{"R5 R6 R8", "R7 R5", "R4 R8", "R6 R8 R4", "R8 R4",
                                  "R7 R4", "R2", "R2", "R1"};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] a, input logic w64, input logic [63:0] d);
    @(negedge clk);
    acc_addr = a; acc_64 = w64; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic w64);
    @(negedge clk);
    acc_addr = a; acc_64 = w64; wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #500us;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; unit_en = 1'b0; acc_addr = '0; acc_64 = 1'b1; wr_en = 1'b0; wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset words
    chk("R9 dev", dev_base, 64'h1907_0000_0000_0600);
    chk("R9 coll", coll_base, 64'h1C07_0000_0000_0600);

    // R2 reserved slot reads as zero
    rd(8'h18, 1'b1);
    chk("R2 read slot3", rd_data, 64'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      do_wr(VEC[i][200:193], VEC[i][192], VEC[i][191:128]);
      chk({VTAG[i], " dev"}, dev_base, VEC[i][127:64]);
      chk({VTAG[i], " coll"}, coll_base, VEC[i][63:0]);
    end

    // R4 read halves and full word
    rd(8'h04, 1'b0);
    chk("R4 read dev upper", rd_data, 64'h0000_0000_4107_0000);
    rd(8'h08, 1'b0);
    chk("R4 read coll lower", rd_data, 64'h0000_0000_0000_0200);
    rd(8'h08, 1'b1);
    chk("R1 read coll full", rd_data, 64'h0407_0000_0000_0200);

    // R3 lock while enabled
    @(negedge clk); unit_en = 1'b1;
    do_wr(8'h00, 1'b1, 64'h0);
    do_wr(8'h08, 1'b1, 64'hFFFF_FFFF_FFFF_FFFF);
    chk("R3 dev locked", dev_base, 64'h4107_0000_0000_0A55);
    chk("R3 coll locked", coll_base, 64'h0407_0000_0000_0200);
    @(negedge clk); unit_en = 1'b0;

    // R10 not visible before the edge, visible after
    @(negedge clk);
    acc_addr = 8'h00; acc_64 = 1'b1; wr_data = 64'h0; wr_en = 1'b1;
    #1;
    chk("R10 before edge", dev_base, 64'h4107_0000_0000_0A55);
    @(negedge clk); wr_en = 1'b0;
    chk("R10 after edge", dev_base, 64'h0107_0000_0000_0200);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule